// File: doc/BRIEF.md
# Two-Register Serial Write Slave

This block is the register front end of a video encoder. It listens on a two-wire serial bus (I2C framing, 7-bit addressing, writes only) and fills two 8-bit control registers: a mode register and a command register. SCL and SDA arrive as plain inputs and are oversampled in the system clock domain. The acknowledge is returned through an open-drain pull-down output. A strap input picks one of two device addresses.

A transfer is a start condition, the address byte with the write bit, a subaddress byte, one or more data bytes, and a stop. Every data byte of one transfer lands on the same subaddress, so the subaddress does not advance. Most register bits take effect as soon as their byte is accepted. The black-level bit and the two overlay-level bits are staged in shadow copies and are committed only when the vertical-blank strobe pulses. When mode bit 7 is set, the video mode, master/slave and interlace selections come from the registers. Otherwise they come from external pins.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset the mode register reads 0x10, the command register reads 0x1B and the SDA pull-down is released.
- R2: The address byte is sent MSB first as 7 address bits followed by the R/W bit (0 = write). The slave acknowledges it only when the address equals 0x46 with addrSel=1, or 0x44 with addrSel=0. Any other address is refused and nothing is written.
- R3: An address byte that matches but has the R/W bit set to 1 is refused, and the rest of that transfer writes nothing.
- R4: Subaddress 0x00 selects the mode register and 0x01 selects the command register. Any other subaddress is refused, and data bytes that follow it in the same transfer are neither acknowledged nor written.
- R5: Every data byte after an accepted subaddress is acknowledged and rewrites the same register. After a burst, the last byte of the burst remains.
- R6: Mode bits 7, 6, 4, 3, 2, 1, 0 and command bits 4, 3, 2 take the written value as soon as the data byte is accepted.
- R7: Mode bit 5 and command bits 1:0 keep their committed value until vBlank pulses. The pulse then loads the most recently written value.
- R8: Command bits 7:5 always read 0, whatever is written.
- R9: When mode bit 7 is 0, videoMode, masterMode and interlaced follow extVideoMode, extMaster and extInterlace. When mode bit 7 is 1, they follow mode bits 2:0, mode bit 4 and command bit 3.
- R10: A start condition in the middle of a byte discards the partial byte and returns the slave to address reception. No register changes because of the discarded byte.
- R11: The acknowledge pull-down turns on after the SCL falling edge that ends the eighth bit. It stays off while that eighth bit is high, and turns off after the next SCL falling edge.
- R12: After a stop condition the pull-down is off, and after a refused byte the slave ignores the bus until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| addrSel | input | 1 | Address strap: 1 selects 0x46, 0 selects 0x44 |
| vBlank | input | 1 | One-cycle vertical-blank strobe that commits shadowed fields |
| extVideoMode | input | 3 | Video mode from pins |
| extMaster | input | 1 | Master/slave select from pin |
| extInterlace | input | 1 | Interlace select from pin |
| modeReg | output | 8 | Committed mode register |
| cmdReg | output | 8 | Committed command register |
| videoMode | output | 3 | Effective video mode |
| masterMode | output | 1 | Effective master/slave select |
| interlaced | output | 1 | Effective interlace select |

## Verification
The bench targets the following corner cases, and each would show up at the ports if handled wrongly:
- Refused transfers. A read-bit address, a wrong or strap-swapped address, or an out-of-range subaddress is followed by further bytes. A slave that forgets a refusal acknowledges those bytes or changes a register.
- Bursts. A burst of data bytes must leave only its last value. An auto-incrementing slave would spill the later bytes into the neighbouring register.
- Shadowed fields. These are checked before and after each blank pulse. An early commit shows the new black-level or overlay bits too soon, and a missed commit never shows them.
- Aborted bytes and acknowledge timing. A restart inside a partial byte, and the acknowledge window sampled at its edges, catch a slave that shifts stale bits into the next address or holds SDA at the wrong time.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_ACK,
    PH_SKIP
  } busPhase_t;

  typedef struct packed {
    logic             wrMode;
    logic             wrCmd;
    logic [REG_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
#(
  parameter int         SYNC_DEPTH  = 2,
  parameter logic [6:0] ADDR_STRAP1 = 7'h46,
  parameter logic [6:0] ADDR_STRAP0 = 7'h44
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  output logic       sdaDriveLow,
  output regStrobe_t stb
);
  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(REG_W);

  logic [SYNC_DEPTH-1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet, receiving;
  busPhase_t phase, nextPhase;
  logic [CNT_W-1:0] bitCnt;
  logic [REG_W-1:0] shiftReg;
  logic subSel, ackOut;
  logic [6:0] devAddr;

  // two-stage (or deeper) synchronizers, bus idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_DEPTH-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_DEPTH-2:0], sdaIn};
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  assign sclQ      = sclSync[SYNC_DEPTH-1];
  assign sdaQ      = sdaSync[SYNC_DEPTH-1];
  assign sclRise   = sclQ & ~sclPrev;
  assign sclFall   = ~sclQ & sclPrev;
  assign startDet  = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign stopDet   = sclQ & sclPrev & ~sdaPrev & sdaQ;
  assign receiving = (phase == PH_ADDR) || (phase == PH_SUB) || (phase == PH_DATA);
  assign devAddr   = addrSel ? ADDR_STRAP1 : ADDR_STRAP0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      nextPhase <= PH_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      subSel    <= 1'b0;
      ackOut    <= 1'b0;
      stb       <= '0;
    end else begin
      stb.wrMode <= 1'b0;
      stb.wrCmd  <= 1'b0;
      if (startDet) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
        ackOut <= 1'b0;
      end else if (stopDet) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
        ackOut <= 1'b0;
      end else if (receiving && sclRise) begin
        shiftReg <= {shiftReg[REG_W-2:0], sdaQ};
        bitCnt   <= bitCnt + 1'b1;
      end else if (receiving && sclFall && bitCnt == FULL_BYTE) begin
        bitCnt <= '0;
        unique case (phase)
          PH_ADDR: begin
            if (shiftReg == {devAddr, 1'b0}) begin
              ackOut    <= 1'b1;
              phase     <= PH_ACK;
              nextPhase <= PH_SUB;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_SUB: begin
            if (shiftReg[REG_W-1:1] == '0) begin
              ackOut    <= 1'b1;
              phase     <= PH_ACK;
              nextPhase <= PH_DATA;
              subSel    <= shiftReg[0];
            end else begin
              phase <= PH_SKIP;
            end
          end
          default: begin
            ackOut     <= 1'b1;
            phase      <= PH_ACK;
            nextPhase  <= PH_DATA;
            stb.wrMode <= ~subSel;
            stb.wrCmd  <= subSel;
            stb.data   <= shiftReg;
          end
        endcase
      end else if (phase == PH_ACK && sclFall) begin
        ackOut <= 1'b0;
        phase  <= nextPhase;
      end
    end
  end

  assign sdaDriveLow = ackOut;

  // R11
  ack_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclQ);
  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);
  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMode, stb.wrCmd}));
  // R5
  write_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMode || stb.wrCmd) |-> sdaDriveLow);
endmodule

// File: rtl/ctlreg_regs.sv
module ctlreg_regs
  import ctlreg_pkg::*;
#(
  parameter logic [REG_W-1:0] MODE_RST = 8'h10,
  parameter logic [REG_W-1:0] CMD_RST  = 8'h1B
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       stb,
  input  logic             vBlank,
  input  logic [2:0]       extVideoMode,
  input  logic             extMaster,
  input  logic             extInterlace,
  output logic [REG_W-1:0] modeReg,
  output logic [REG_W-1:0] cmdReg,
  output logic [2:0]       videoMode,
  output logic             masterMode,
  output logic             interlaced
);
  localparam int CMD_USED = 5;

  logic [REG_W-1:0]    modeQ;
  logic [CMD_USED-1:0] cmdQ;
  logic                pendBlack;
  logic [1:0]          pendOverlay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MODE_RST;
      cmdQ        <= CMD_RST[CMD_USED-1:0];
      pendBlack   <= MODE_RST[5];
      pendOverlay <= CMD_RST[1:0];
    end else begin
      if (stb.wrMode) begin
        modeQ[7:6] <= stb.data[7:6];
        modeQ[4:0] <= stb.data[4:0];
        pendBlack  <= stb.data[5];
      end
      if (stb.wrCmd) begin
        cmdQ[4:2]   <= stb.data[4:2];
        pendOverlay <= stb.data[1:0];
      end
      if (vBlank) begin
        modeQ[5]  <= stb.wrMode ? stb.data[5] : pendBlack;
        cmdQ[1:0] <= stb.wrCmd ? stb.data[1:0] : pendOverlay;
      end
    end
  end

  assign modeReg = modeQ;
  assign cmdReg  = {{(REG_W-CMD_USED){1'b0}}, cmdQ};

  always_comb begin
    if (modeQ[7]) begin
      videoMode  = modeQ[2:0];
      masterMode = modeQ[4];
      interlaced = cmdQ[3];
    end else begin
      videoMode  = extVideoMode;
      masterMode = extMaster;
      interlaced = extInterlace;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vBlank |=> ($stable(modeReg[5]) && $stable(cmdReg[1:0])));
  // R6
  immediate_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMode |=> (modeReg[4:0] == $past(stb.data[4:0]) && modeReg[7:6] == $past(stb.data[7:6])));
  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrMode && !vBlank) |=> $stable(modeReg));
endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
  import ctlreg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic       addrSel,
  input  logic       vBlank,
  input  logic [2:0] extVideoMode,
  input  logic       extMaster,
  input  logic       extInterlace,
  output logic [7:0] modeReg,
  output logic [7:0] cmdReg,
  output logic [2:0] videoMode,
  output logic       masterMode,
  output logic       interlaced
);
  regStrobe_t stb;

  ctlreg_ctrl #(
    .SYNC_DEPTH (2),
    .ADDR_STRAP1(7'h46),
    .ADDR_STRAP0(7'h44)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .addrSel    (addrSel),
    .sdaDriveLow(sdaDriveLow),
    .stb        (stb)
  );

  ctlreg_regs #(
    .MODE_RST(8'h10),
    .CMD_RST (8'h1B)
  ) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .vBlank      (vBlank),
    .extVideoMode(extVideoMode),
    .extMaster   (extMaster),
    .extInterlace(extInterlace),
    .modeReg     (modeReg),
    .cmdReg      (cmdReg),
    .videoMode   (videoMode),
    .masterMode  (masterMode),
    .interlaced  (interlaced)
  );
endmodule

// File: tb/ctlreg_i2c_slave_tb.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaBus, sdaDriveLow;
  logic addrSel = 1'b0, vBlank = 1'b0;
  logic [2:0] extVideoMode = 3'd0;
  logic extMaster = 1'b0, extInterlace = 1'b0;
  logic [7:0] modeReg, cmdReg;
  logic [2:0] videoMode;
  logic masterMode, interlaced;

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  logic [7:0] expMode = 8'h10, expCmd = 8'h1B;
  logic pendBlack = 1'b0;
  logic [1:0] pendOverlay = 2'b11;

  always #5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaDriveLow;

  ctlreg_i2c_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow),
    .addrSel(addrSel), .vBlank(vBlank), .extVideoMode(extVideoMode),
    .extMaster(extMaster), .extInterlace(extInterlace), .modeReg(modeReg),
    .cmdReg(cmdReg), .videoMode(videoMode), .masterMode(masterMode),
    .interlaced(interlaced)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] devOf(input logic sel);
    return sel ? 7'h46 : 7'h44;
  endfunction

  function automatic logic [4:0] expEff();
    if (expMode[7]) return {expMode[2:0], expMode[4], expCmd[3]};
    return {extVideoMode, extMaster, extInterlace};
  endfunction

  task automatic modelWrite(input logic sub, input logic [7:0] d);
    if (!sub) begin
      expMode = {d[7:6], expMode[5], d[4:0]};
      pendBlack = d[5];
    end else begin
      expCmd = {3'b000, d[4:2], expCmd[1:0]};
      pendOverlay = d[1:0];
    end
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitH();
    sclM = 1'b1; waitH();
    sdaM = 1'b0; waitH();
    sclM = 1'b0; waitH();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitH();
    sclM = 1'b1; waitH();
    sdaM = 1'b1; waitH();
  endtask

  task automatic sendBits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sdaM = b[i]; waitH();
      sclM = 1'b1; waitH();
      sclM = 1'b0; waitH();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked,
                          output logic early, output logic late);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitH();
      sclM = 1'b1; waitH();
      if (i == 0) early = sdaDriveLow;
      sclM = 1'b0; waitH();
    end
    sdaM = 1'b1; waitH();
    sclM = 1'b1; waitH();
    acked = ~sdaBus;
    sclM = 1'b0; waitH();
    late = sdaDriveLow;
  endtask

  task automatic pulseBlank();
    vBlank = 1'b1; @(negedge clk);
    vBlank = 1'b0; @(negedge clk);
    expMode[5] = pendBlack;
    expCmd[1:0] = pendOverlay;
  endtask

  task automatic checkRegs(input string tag);
    chk({tag, " R6/R7 mode"}, modeReg, expMode);
    chk({tag, " R6/R7 cmd"}, cmdReg, expCmd);
    chk({tag, " R8 cmd upper"}, cmdReg[7:5], 3'b000);
    chk({tag, " R9 effective"}, {videoMode, masterMode, interlaced}, expEff());
    chk({tag, " R12 released"}, sdaDriveLow, 1'b0);
  endtask

  task automatic writeTxn(input logic [7:0] addrByte, input logic [7:0] sub,
                          input logic [23:0] ds, input int n, input string tag);
    logic a, e, l, ok;
    busStart();
    ok = (addrByte == {devOf(addrSel), 1'b0});
    sendByte(addrByte, a, e, l);
    chk({tag, " R2/R3 address ack"}, a, ok);
    chk({tag, " R11 no early ack"}, e, 1'b0);
    chk({tag, " R11 ack released"}, l, 1'b0);
    ok = ok && (sub < 8'd2);
    sendByte(sub, a, e, l);
    chk({tag, " R4 subaddress ack"}, a, ok);
    for (int k = 0; k < n; k++) begin
      sendByte(ds[8*k +: 8], a, e, l);
      chk({tag, " R5/R12 data ack"}, a, ok);
      if (ok) modelWrite(sub[0], ds[8*k +: 8]);
    end
    busStop();
    waitH();
    checkRegs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic a, e, l;
    void'($urandom(32'd4242));
    extVideoMode = 3'd2; extMaster = 1'b1; extInterlace = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mode reset", modeReg, 8'h10);
    chk("R1 cmd reset", cmdReg, 8'h1B);
    chk("R1 sda released", sdaDriveLow, 1'b0);
    chk("R9 pins at reset", {videoMode, masterMode, interlaced}, {3'd2, 1'b1, 1'b0});

    // R6, R7: mode with shadowed bit 5
    writeTxn({7'h44, 1'b0}, 8'h00, 24'h0000E5, 1, "mode write");
    chk("R7 bit5 held before blank", modeReg[5], 1'b0);
    pulseBlank();
    chk("R7 bit5 after blank", modeReg, 8'hE5);
    chk("R9 register control", {videoMode, masterMode, interlaced}, {3'd5, 1'b0, 1'b1});

    // R8, R7: command write
    writeTxn({7'h44, 1'b0}, 8'h01, 24'h0000FC, 1, "cmd write");
    chk("R8/R7 cmd before blank", cmdReg, 8'h1F);
    pulseBlank();
    chk("R7 cmd after blank", cmdReg, 8'h1C);

    // R5 burst stays on one subaddress
    writeTxn({7'h44, 1'b0}, 8'h01, 24'h100804, 3, "burst");
    chk("R5 burst last wins", cmdReg[4:2], 3'b100);
    chk("R5 no increment", modeReg, 8'hE5);

    // R4 invalid subaddress, R3 read bit, R2 wrong address and strap
    writeTxn({7'h44, 1'b0}, 8'h02, 24'h0000FF, 1, "bad sub");
    writeTxn({7'h44, 1'b0}, 8'h80, 24'h0000FF, 1, "bad sub high");
    writeTxn({7'h44, 1'b1}, 8'h00, 24'h000000, 1, "R3 read bit");
    writeTxn({7'h46, 1'b0}, 8'h00, 24'h000000, 1, "R2 other strap");
    addrSel = 1'b1;
    writeTxn({7'h46, 1'b0}, 8'h00, 24'h000011, 1, "R2 strap one");
    writeTxn({7'h44, 1'b0}, 8'h00, 24'h000000, 1, "R2 strap one old");

    // R10 restart inside a data byte and inside an address byte
    busStart();
    sendByte({7'h46, 1'b0}, a, e, l);
    sendByte(8'h00, a, e, l);
    sendBits(8'hAA, 5);
    writeTxn({7'h46, 1'b0}, 8'h01, 24'h000008, 1, "R10 abort data");
    busStart();
    sendBits(8'h8C, 3);
    writeTxn({7'h46, 1'b0}, 8'h00, 24'h000003, 1, "R10 abort addr");

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic [7:0] ab, sb;
      logic [23:0] ds;
      int n, pick;
      addrSel = 1'($urandom());
      extVideoMode = 3'($urandom());
      extMaster = 1'($urandom());
      extInterlace = 1'($urandom());
      pick = $urandom_range(0, 9);
      ab = {devOf(addrSel), 1'b0};
      if (pick == 0) ab = {devOf(~addrSel), 1'b0};
      if (pick == 1) ab = {devOf(addrSel), 1'b1};
      sb = 8'($urandom_range(0, 1));
      if (pick == 2) sb = 8'($urandom_range(2, 255));
      ds = 24'($urandom());
      n = $urandom_range(1, 3);
      writeTxn(ab, sb, ds, n, "random");
      if ($urandom_range(0, 2) == 0) begin
        pulseBlank();
        checkRegs("random blank");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule